// File: doc/BRIEF.md
# Four-Axis Game Port Position Meter

This block turns the digital timing pulses of up to four joystick axes into position counts. Each axis drives a "still timing" input. The input stays high for a time that grows with the axis position. After a measurement starts, the block counts clock ticks for every enabled axis until that axis's input drops. A programmable prescaler sets the tick rate. When every enabled axis has stopped, the counts move into a result latch and a ready flag rises.

Software controls the block through two 8-bit registers and one 16-bit value port. The axis register holds the per-axis enables, the readback select, the continuous mode bit and, as a read-only bit, the ready flag. The hardware register holds the interrupt enable and the rate code. Writing the value port starts a measurement, and reading it clears the ready flag. In continuous mode a new measurement starts by itself as soon as the previous one has been latched, so the latch keeps following the stick without software action.

Top module: `gameport_axis_meter`

## Requirements
- R1: Axis register bits 3:0 enable axes 1 to 4. A disabled axis does not count, and its latched result keeps its earlier value across measurements, whatever its timing input does.
- R2: Axis register bits 5:4 select the axis shown on `valRdData`: 00 selects axis 1, 01 axis 2, 10 axis 3 and 11 axis 4.
- R3: A `valWr` pulse starts a measurement. Each enabled counter starts at zero and stops at the first clock edge after the start edge at which its input is low. With H edges of high input after the start edge and divisor D, the result is floor(H/D).
- R4: Axis register bit 7 reads 1 once all enabled axes have stopped and their counts are latched. A `valRd` pulse or a `valWr` pulse clears it, and a write to bit 7 has no effect on it.
- R5: Hardware register bits 2:1 set the divisor D: code 00 gives 1, 10 gives 2, 01 gives 20 and 11 gives 200.
- R6: A counter that reaches 0xFFFF stays at 0xFFFF for the rest of the measurement.
- R7: When axis register bit 6 is set, a new measurement starts automatically in the cycle its predecessor is latched, and the ready flag rises again without any `valWr`.
- R8: `irq` is high exactly while the ready flag is 1 and hardware register bit 0 is 1.
- R9: Hardware register bits 3:0 read back as written, and bits 7:4 always read 0.
- R10: After reset, both registers, every latched result and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for the axis register |
| cfgWrData | input | 8 | Axis register write data |
| cfgRdData | output | 8 | Axis register readback, ready flag in bit 7 |
| hwWrEn | input | 1 | Write strobe for the hardware register |
| hwWrData | input | 8 | Hardware register write data |
| hwRdData | output | 8 | Hardware register readback |
| valWr | input | 1 | Value port write strobe, starts a measurement |
| valRd | input | 1 | Value port read strobe, clears the ready flag |
| valRdData | output | 16 | Latched result of the selected axis |
| axisActive | input | 4 | Per-axis timing inputs, high while timing |
| irq | output | 1 | Measurement-ready interrupt |

## Verification
The bench aims at the edge counting, where an off-by-one start or stop would shift every result by one tick. It also covers each rate code, because a swapped code mapping shows up as wrong quotients such as 2 against 20. Disabled axes have live inputs during measurements, so a design that counted them or overwrote their latches would change values the bench expects to stay put. Further tests drive a long pulse that must pin at 0xFFFF and not wrap. They also check that continuous mode re-arms with no trigger, that a write to the ready bit is ignored, and that the interrupt follows both the ready flag and its enable.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  localparam int NUM_AXES = 4;
  localparam int SEL_W    = $clog2(NUM_AXES);

  typedef struct packed {
    logic start;    // clear counters, arm enabled axes
    logic tick;     // prescaled count enable
    logic capture;  // copy counts of enabled axes into the latch
  } dpStrobe_t;
endpackage

// File: rtl/gpm_ctrl.sv
module gpm_ctrl
  import gpm_pkg::*;
#(
  parameter int DIV_HALF      = 2,
  parameter int DIV_TWENTIETH = 20,
  parameter int DIV_SLOW      = 200
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [7:0]          cfgWrData,
  input  logic                hwWrEn,
  input  logic [7:0]          hwWrData,
  input  logic                valWr,
  input  logic                valRd,
  input  logic                allStopped,
  output dpStrobe_t           strobe,
  output logic [NUM_AXES-1:0] axisEn,
  output logic [SEL_W-1:0]    axisSel,
  output logic [7:0]          cfgRdData,
  output logic [7:0]          hwRdData,
  output logic                irq
);
  localparam int MAX_DIV_A = (DIV_HALF > DIV_TWENTIETH) ? DIV_HALF : DIV_TWENTIETH;
  localparam int MAX_DIV   = (MAX_DIV_A > DIV_SLOW) ? MAX_DIV_A : DIV_SLOW;
  localparam int PRE_W     = $clog2(MAX_DIV + 1);

  logic [NUM_AXES-1:0] enQ;
  logic [SEL_W-1:0]    selQ;
  logic                contQ;
  logic                irqEnQ;
  logic [1:0]          rateQ;
  logic                legacyQ;
  logic                measuring;
  logic                ready;
  logic [PRE_W-1:0]    presc;
  logic [PRE_W-1:0]    divisor;
  logic                finish;
  logic                start;
  logic                tick;

  always_comb begin
    case (rateQ)
      2'b00:   divisor = PRE_W'(1);
      2'b10:   divisor = PRE_W'(DIV_HALF);
      2'b01:   divisor = PRE_W'(DIV_TWENTIETH);
      default: divisor = PRE_W'(DIV_SLOW);
    endcase
  end

  assign finish = measuring && allStopped && !valWr;
  assign start  = valWr || (finish && contQ);
  assign tick   = measuring && !start && (presc >= divisor - PRE_W'(1));

  assign strobe = '{start: start, tick: tick, capture: finish};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= '0;
      selQ    <= '0;
      contQ   <= 1'b0;
      irqEnQ  <= 1'b0;
      rateQ   <= 2'b00;
      legacyQ <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        enQ   <= cfgWrData[NUM_AXES-1:0];
        selQ  <= cfgWrData[5:4];
        contQ <= cfgWrData[6];
      end
      if (hwWrEn) begin
        irqEnQ  <= hwWrData[0];
        rateQ   <= hwWrData[2:1];
        legacyQ <= hwWrData[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measuring <= 1'b0;
      ready     <= 1'b0;
      presc     <= '0;
    end else begin
      if (start)       measuring <= 1'b1;
      else if (finish) measuring <= 1'b0;

      if (finish)              ready <= 1'b1;
      else if (valWr || valRd) ready <= 1'b0;

      if (start)          presc <= '0;
      else if (tick)      presc <= '0;
      else if (measuring) presc <= presc + PRE_W'(1);
    end
  end

  assign axisEn    = enQ;
  assign axisSel   = selQ;
  assign cfgRdData = {ready, contQ, selQ, enQ};
  assign hwRdData  = {4'b0000, legacyQ, rateQ, irqEnQ};
  assign irq       = ready && irqEnQ;

  // R4: ready only rises as the conclusion of a running measurement
  a_r4_ready_after_measure: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(measuring));

  // R4: a read with no measurement in flight drops the flag
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (valRd && !measuring) |=> !ready);

  // R5: the prescaler never runs past the largest divisor
  a_r5_presc_bound: assert property (@(posedge clk) disable iff (!rstN)
    presc <= PRE_W'(MAX_DIV));
endmodule

// File: rtl/gpm_datapath.sv
module gpm_datapath
  import gpm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [NUM_AXES-1:0] axisEn,
  input  logic [NUM_AXES-1:0] axisActive,
  input  logic [SEL_W-1:0]    axisSel,
  output logic [CNT_W-1:0]    valRdData,
  output logic                allStopped
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_AXES-1:0] running;
  logic [CNT_W-1:0]    cnt    [NUM_AXES];
  logic [CNT_W-1:0]    latchQ [NUM_AXES];

  for (genvar i = 0; i < NUM_AXES; i++) begin : g_axis
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        running[i] <= 1'b0;
        cnt[i]     <= '0;
      end else if (strobe.start) begin
        running[i] <= axisEn[i];
        if (axisEn[i]) cnt[i] <= '0;
      end else if (running[i]) begin
        if (!axisActive[i])                   running[i] <= 1'b0;
        else if (strobe.tick && cnt[i] != CNT_MAX) cnt[i] <= cnt[i] + CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          latchQ[i] <= '0;
      else if (strobe.capture && axisEn[i]) latchQ[i] <= cnt[i];
    end

    // R6: a pinned counter stays pinned until restarted
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rstN)
      (running[i] && cnt[i] == CNT_MAX && !strobe.start) |=> cnt[i] == CNT_MAX);

    // R3: between starts a count never goes down
    a_r3_monotonic: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.start |=> cnt[i] >= $past(cnt[i]));

    // R3: an axis stops only on a low input or a restart
    a_r3_stop_on_low: assert property (@(posedge clk) disable iff (!rstN)
      $fell(running[i]) |-> ($past(!axisActive[i]) || $past(strobe.start)));

    // R1: a disabled axis keeps its latched result
    a_r1_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
      !axisEn[i] |=> $stable(latchQ[i]));
  end

  assign allStopped = (running == '0);
  assign valRdData  = latchQ[axisSel];
endmodule

// File: rtl/gameport_axis_meter.sv
module gameport_axis_meter
  import gpm_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int DIV_HALF      = 2,
  parameter int DIV_TWENTIETH = 20,
  parameter int DIV_SLOW      = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  output logic [7:0]       cfgRdData,
  input  logic             hwWrEn,
  input  logic [7:0]       hwWrData,
  output logic [7:0]       hwRdData,
  input  logic             valWr,
  input  logic             valRd,
  output logic [CNT_W-1:0] valRdData,
  input  logic [3:0]       axisActive,
  output logic             irq
);
  dpStrobe_t           strobe;
  logic [NUM_AXES-1:0] axisEn;
  logic [SEL_W-1:0]    axisSel;
  logic                allStopped;

  gpm_ctrl #(
    .DIV_HALF(DIV_HALF), .DIV_TWENTIETH(DIV_TWENTIETH), .DIV_SLOW(DIV_SLOW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .hwWrEn(hwWrEn), .hwWrData(hwWrData),
    .valWr(valWr), .valRd(valRd),
    .allStopped(allStopped),
    .strobe(strobe), .axisEn(axisEn), .axisSel(axisSel),
    .cfgRdData(cfgRdData), .hwRdData(hwRdData), .irq(irq)
  );

  gpm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .axisEn(axisEn), .axisActive(axisActive),
    .axisSel(axisSel), .valRdData(valRdData), .allStopped(allStopped)
  );

  // R4: the flag rises only after every armed axis had stopped
  a_r4_ready_means_stopped: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgRdData[7]) |-> $past(allStopped));
endmodule

// File: tb/gameport_axis_meter_bench.sv
module gameport_axis_meter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        hwWrEn = 1'b0;
  logic [7:0]  hwWrData = '0;
  logic [7:0]  hwRdData;
  logic        valWr = 1'b0;
  logic        valRd = 1'b0;
  logic [15:0] valRdData;
  logic [3:0]  axisActive = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] expLatch [4];

  always #2.5 clk = ~clk;

  gameport_axis_meter u_gameport_axis_meter (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .hwWrEn(hwWrEn), .hwWrData(hwWrData), .hwRdData(hwRdData),
    .valWr(valWr), .valRd(valRd), .valRdData(valRdData),
    .axisActive(axisActive), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  en;
    logic [1:0]  rate;
    logic [15:0] h0, h1, h2, h3;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{en: 4'hF, rate: 2'b00, h0: 16'd5,   h1: 16'd9,  h2: 16'd1,  h3: 16'd0},
    '{en: 4'h5, rate: 2'b10, h0: 16'd7,   h1: 16'd3,  h2: 16'd8,  h3: 16'd4},
    '{en: 4'hA, rate: 2'b01, h0: 16'd45,  h1: 16'd40, h2: 16'd61, h3: 16'd19},
    '{en: 4'h1, rate: 2'b11, h0: 16'd450, h1: 16'd7,  h2: 16'd7,  h3: 16'd7},
    '{en: 4'hF, rate: 2'b00, h0: 16'd0,   h1: 16'd0,  h2: 16'd0,  h3: 16'd0},
    '{en: 4'h3, rate: 2'b10, h0: 16'd13,  h1: 16'd2,  h2: 16'd9,  h3: 16'd9}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int divOf(input logic [1:0] rate);
    case (rate)
      2'b00: return 1;
      2'b10: return 2;
      2'b01: return 20;
      default: return 200;
    endcase
  endfunction

  task automatic wrCfg(input logic [7:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic wrHw(input logic [7:0] d);
    @(negedge clk); hwWrEn = 1'b1; hwWrData = d;
    @(negedge clk); hwWrEn = 1'b0;
  endtask

  task automatic pulseRd();
    @(negedge clk); valRd = 1'b1;
    @(negedge clk); valRd = 1'b0;
  endtask

  // Start, then hold axis i high for h[i] edges after the start edge
  task automatic measure(input logic [3:0] en, input logic [6:4] upper, input int h [4]);
    int maxH = 0;
    for (int i = 0; i < 4; i++) if (h[i] > maxH) maxH = h[i];
    wrCfg({1'b0, upper, en});
    @(negedge clk); valWr = 1'b1; axisActive = '0;
    @(negedge clk); valWr = 1'b0;
    for (int t = 1; t <= maxH + 1; t++) begin
      for (int i = 0; i < 4; i++) axisActive[i] = (t <= h[i]);
      @(negedge clk);
    end
    axisActive = '0;
  endtask

  task automatic waitReady(input string tag);
    int n = 0;
    while (!cfgRdData[7] && n < 20) begin @(negedge clk); n++; end
    check(cfgRdData[7] == 1'b1, tag, cfgRdData[7], 1);
  endtask

  task automatic readAxis(input logic [3:0] en, input logic cont, input int idx,
                          output logic [15:0] v);
    wrCfg({1'b0, cont, 2'(idx), en});
    @(negedge clk);
    v = valRdData;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int h [4];
    for (int i = 0; i < 4; i++) expLatch[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    check(cfgRdData == 8'h00, "R10 cfg reset", cfgRdData, 0);
    check(hwRdData == 8'h00, "R10 hw reset", hwRdData, 0);
    check(valRdData == 16'h0, "R10 latch reset", valRdData, 0);
    check(irq == 1'b0, "R10 irq reset", irq, 0);

    // R1 R2 R3 R5: table of measurements
    for (int k = 0; k < NV; k++) begin
      wrHw({5'b0, VECS[k].rate, 1'b0});
      h[0] = int'(VECS[k].h0); h[1] = int'(VECS[k].h1);
      h[2] = int'(VECS[k].h2); h[3] = int'(VECS[k].h3);
      measure(VECS[k].en, 3'b000, h);
      waitReady("R4 ready after table vector");
      for (int i = 0; i < 4; i++)
        if (VECS[k].en[i]) expLatch[i] = 16'(h[i] / divOf(VECS[k].rate));
      for (int i = 0; i < 4; i++) begin
        readAxis(VECS[k].en, 1'b0, i, v);
        check(v == expLatch[i], "R1 R2 R3 R5 axis result", v, expLatch[i]);
      end
      check(irq == 1'b0, "R8 irq masked", irq, 0);
      pulseRd();
    end

    // R4: read cleared the flag; writing bit 7 does not set it
    @(negedge clk);
    check(cfgRdData[7] == 1'b0, "R4 read clears ready", cfgRdData[7], 0);
    wrCfg(8'h81);
    @(negedge clk);
    check(cfgRdData[7] == 1'b0, "R4 bit7 write ignored", cfgRdData[7], 0);

    // R9: hardware register readback
    wrHw(8'hFF);
    @(negedge clk);
    check(hwRdData == 8'h0F, "R9 hw readback", hwRdData, 8'h0F);

    // R8: interrupt follows ready with enable
    wrHw(8'h01);
    h = '{3, 0, 0, 0};
    measure(4'h1, 3'b000, h);
    waitReady("R4 ready for irq test");
    check(irq == 1'b1, "R8 irq asserted", irq, 1);
    pulseRd();
    @(negedge clk);
    check(irq == 1'b0, "R8 irq cleared by read", irq, 0);
    wrHw(8'h00);

    // R6: saturation at full rate
    h = '{70000, 0, 0, 0};
    measure(4'h1, 3'b000, h);
    waitReady("R4 ready after long pulse");
    readAxis(4'h1, 1'b0, 0, v);
    check(v == 16'hFFFF, "R6 saturation", v, 16'hFFFF);
    pulseRd();

    // R7: continuous mode re-arms without a trigger
    h = '{4, 0, 0, 0};
    measure(4'h1, 3'b100, h);
    waitReady("R7 first continuous result");
    readAxis(4'h1, 1'b1, 0, v);
    check(v == 16'd4 || v == 16'd0, "R7 continuous first value", v, 4);
    pulseRd();
    repeat (6) @(negedge clk);
    check(cfgRdData[7] == 1'b1, "R7 ready re-rises", cfgRdData[7], 1);
    check(valRdData == 16'd0, "R7 relatched low input", valRdData, 0);
    wrCfg(8'h01);
    repeat (4) @(negedge clk);
    pulseRd();
    repeat (10) @(negedge clk);
    check(cfgRdData[7] == 1'b0, "R7 stops when mode off", cfgRdData[7], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule